// File: doc/BRIEF.md
# Release-Point Bus Arbiter

This block decides which of three masters drives a shared on-chip bus: a processor core, a descriptor-driven transfer engine (DTC), and a DMA controller. Priority is fixed: DMA first, then DTC, then the processor. A higher-priority request does not cut into the current owner's work. The grant moves only when the owner signals that it has reached a point where it may let go, and not while it flags a transfer that must stay whole.

The processor owns the bus whenever nobody else needs it. Each master reports a release strobe, which marks the end of a bus cycle or a transfer phase, and a lock flag, which marks a split access or a phase that must not be broken up. The DMA does not give a single strobe. It reports three end events: one transfer, one block, or the whole job. A 2-bit mode input selects which of these counts as its release point. When the processor is asleep it gives up the bus on the next clock edge, whatever its strobe and lock show. The grant is registered and one-hot. A handover leaves no idle cycle between owners.

Top module: `relpt_bus_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `gnt` is 3'b001: the processor owns the bus. Bit 0 is the processor, bit 1 the DTC and bit 2 the DMA.
- R2: `gnt` has exactly one bit set in every cycle after reset.
- R3: If the current owner is not at a release point, `gnt` keeps its value on the next edge, whatever requests are active. The processor while asleep is the exception (R6).
- R4: At a release point, the next owner is the DMA if `req_dma` is high, otherwise the DTC if `req_dtc` is high, otherwise the processor. The new grant shows on the edge right after the release cycle, with no idle cycle in between.
- R5: The processor's release strobe `cpu_rel` has no effect while `cpu_lock` is high, for example between the two halves of a longword access.
- R6: While `cpu_sleep` is high and the processor owns the bus, a DTC or DMA request is granted on the next edge, regardless of `cpu_rel` and `cpu_lock`.
- R7: The DTC gives up the bus only on `dtc_rel` with `dtc_lock` low. A strobe raised while the lock is set is ignored.
- R8: With `dma_mode` 0 (single transfer) or 1 (cycle steal), `dma_xfer_end` is a DMA release point.
- R9: With `dma_mode` 2 (block), only `dma_block_end` releases the DMA. `dma_xfer_end` is ignored.
- R10: With `dma_mode` 3 (burst), only `dma_all_end` releases the DMA. `dma_xfer_end` and `dma_block_end` are ignored.
- R11: `bus_idle` is high exactly when the processor owns the bus, `cpu_sleep` is high, and neither `req_dtc` nor `req_dma` is high.
- R12: An owner that is still the highest-priority requester at its own release point keeps the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_sleep | input | 1 | Processor is in sleep mode |
| cpu_rel | input | 1 | Processor is at a bus-cycle boundary |
| cpu_lock | input | 1 | Processor is inside a split access |
| req_dtc | input | 1 | DTC bus request |
| dtc_rel | input | 1 | DTC finished a phase (vector read, register read, data move or register write) |
| dtc_lock | input | 1 | DTC is inside a phase that must not be broken up |
| req_dma | input | 1 | DMA bus request |
| dma_mode | input | 2 | 0 single, 1 cycle steal, 2 block, 3 burst |
| dma_xfer_end | input | 1 | DMA finished one transfer |
| dma_block_end | input | 1 | DMA finished one block |
| dma_all_end | input | 1 | DMA finished the whole job |
| dma_lock | input | 1 | DMA must not be released this cycle |
| gnt | output | 3 | One-hot grant: bit 0 processor, bit 1 DTC, bit 2 DMA |
| bus_idle | output | 1 | Processor owns the bus while asleep and nobody is requesting |

## Verification
The bench builds the arbiter with the package defaults: three masters and a 2-bit DMA mode. With these values every pairing of owner and requester can be reached, and so can all four DMA release modes. The scenarios drive release strobes while the lock is held, and end events that the current DMA mode does not count, and check that the grant stays put. They also show that a still-requesting DMA keeps the bus across its own release points, and that a sleeping processor gives up the bus even while its lock is set.

// File: rtl/relpt_pkg.sv
// Shared constants for the release-point bus arbiter.
// Assumes the master order gives priority: a higher index wins.
package relpt_pkg;
    localparam int N_MST  = 3;
    localparam int MODE_W = 2;
    localparam int CPU_IX = 0;
    localparam int DTC_IX = 1;
    localparam int DMA_IX = 2;

    typedef enum logic [MODE_W-1:0] {
        DMA_SINGLE = 2'd0,
        DMA_STEAL  = 2'd1,
        DMA_BLOCK  = 2'd2,
        DMA_BURST  = 2'd3
    } dma_mode_e;
endpackage

// File: rtl/relpt_dma_point.sv
// Turns the DMA's three end events into one release strobe, according to
// the transfer mode.
// Assumes every event is a one-cycle strobe raised by the DMA itself.
module relpt_dma_point
    import relpt_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              xfer_end,
    input  logic              block_end,
    input  logic              all_end,
    output logic              rel
);
    // Pick the end event that counts as a release point in this mode.
    always_comb begin
        case (dma_mode_e'(mode))
            DMA_SINGLE, DMA_STEAL: rel = xfer_end;
            DMA_BLOCK:             rel = block_end;
            DMA_BURST:             rel = all_end;
            default:               rel = 1'b0;
        endcase
    end
endmodule

// File: rtl/relpt_gate.sv
// Decides whether the current owner may give up the bus in this cycle.
// Assumes owner is one-hot, and that index 0 is the processor, the only
// master that may also give up the bus by sleeping.
module relpt_gate #(
    parameter int N = 3
) (
    input  logic [N-1:0] owner,
    input  logic [N-1:0] rel,
    input  logic [N-1:0] lock,
    input  logic         cpu_sleep,
    output logic         open_pt
);
    logic [N-1:0] may_go;

    for (genvar i = 0; i < N; i++) begin : g_mst
        if (i == 0) begin : g_cpu
            // The processor lets go at an unlocked boundary, or at once while asleep.
            assign may_go[i] = owner[i] & ((rel[i] & ~lock[i]) | cpu_sleep);
        end else begin : g_oth
            // Other masters let go only at an unlocked release point.
            assign may_go[i] = owner[i] & rel[i] & ~lock[i];
        end
    end

    assign open_pt = |may_go;
endmodule

// File: rtl/relpt_prio.sv
// Fixed-priority pick: the highest index with a request set wins.
// Assumes bit 0 is always requesting, so the result is never empty.
module relpt_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    // Scan upward so that the highest requesting index is the last one written.
    always_comb begin
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/relpt_bus_arbiter.sv
// Top level of the release-point bus arbiter. Holds the registered one-hot
// grant. The grant moves only when the owner's release gate opens, and then
// goes to the highest-priority requester, with the processor as the fallback.
// Assumes all inputs are synchronous to clk.
module relpt_bus_arbiter
    import relpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sleep,
    input  logic              cpu_rel,
    input  logic              cpu_lock,
    input  logic              req_dtc,
    input  logic              dtc_rel,
    input  logic              dtc_lock,
    input  logic              req_dma,
    input  logic [MODE_W-1:0] dma_mode,
    input  logic              dma_xfer_end,
    input  logic              dma_block_end,
    input  logic              dma_all_end,
    input  logic              dma_lock,
    output logic [N_MST-1:0]  gnt,
    output logic              bus_idle
);
    logic [N_MST-1:0] gnt_q;
    logic [N_MST-1:0] rel_vec;
    logic [N_MST-1:0] lock_vec;
    logic [N_MST-1:0] req_vec;
    logic [N_MST-1:0] pick;
    logic             dma_rel;
    logic             open_pt;

    relpt_dma_point u_dma_point (
        .mode      (dma_mode),
        .xfer_end  (dma_xfer_end),
        .block_end (dma_block_end),
        .all_end   (dma_all_end),
        .rel       (dma_rel)
    );

    // Gather the per-master status, placing each signal at its priority index.
    always_comb begin
        rel_vec          = '0;
        lock_vec         = '0;
        req_vec          = '0;
        rel_vec[CPU_IX]  = cpu_rel;
        rel_vec[DTC_IX]  = dtc_rel;
        rel_vec[DMA_IX]  = dma_rel;
        lock_vec[CPU_IX] = cpu_lock;
        lock_vec[DTC_IX] = dtc_lock;
        lock_vec[DMA_IX] = dma_lock;
        req_vec[CPU_IX]  = 1'b1;
        req_vec[DTC_IX]  = req_dtc;
        req_vec[DMA_IX]  = req_dma;
    end

    relpt_gate #(.N(N_MST)) u_gate (
        .owner     (gnt_q),
        .rel       (rel_vec),
        .lock      (lock_vec),
        .cpu_sleep (cpu_sleep),
        .open_pt   (open_pt)
    );

    relpt_prio #(.N(N_MST)) u_prio (
        .req  (req_vec),
        .pick (pick)
    );

    // Grant register: reset to the processor, load the pick when the gate opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= N_MST'(1) << CPU_IX;
        end else if (open_pt) begin
            gnt_q <= pick;
        end
    end

    assign gnt      = gnt_q;
    assign bus_idle = gnt_q[CPU_IX] & cpu_sleep & ~req_dtc & ~req_dma;

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_q) == 1);

    // R3
    hold_without_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_pt |=> $stable(gnt_q));

    // R5
    cpu_lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q[CPU_IX] && cpu_lock && !cpu_sleep) |=> $stable(gnt_q));

    // R6
    sleep_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q[CPU_IX] && cpu_sleep && req_dma) |=> gnt_q[DMA_IX]);

    // R10
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q[DMA_IX] && dma_mode == DMA_BURST && !dma_all_end) |=> gnt_q[DMA_IX]);

    // R4
    dma_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_pt && req_dma) |=> gnt_q[DMA_IX]);
endmodule

// File: tb/relpt_bus_arbiter_bench.sv
`timescale 1ns/1ps
module relpt_bus_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_sleep, cpu_rel, cpu_lock;
    logic       req_dtc, dtc_rel, dtc_lock;
    logic       req_dma, dma_xfer_end, dma_block_end, dma_all_end, dma_lock;
    logic [1:0] dma_mode;
    logic [2:0] gnt;
    logic       bus_idle;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [2:0] G_CPU = 3'b001;
    localparam logic [2:0] G_DTC = 3'b010;
    localparam logic [2:0] G_DMA = 3'b100;

    always #2.5 clk = ~clk;

    relpt_bus_arbiter u_relpt_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .cpu_sleep(cpu_sleep), .cpu_rel(cpu_rel),
        .cpu_lock(cpu_lock), .req_dtc(req_dtc), .dtc_rel(dtc_rel),
        .dtc_lock(dtc_lock), .req_dma(req_dma), .dma_mode(dma_mode),
        .dma_xfer_end(dma_xfer_end), .dma_block_end(dma_block_end),
        .dma_all_end(dma_all_end), .dma_lock(dma_lock), .gnt(gnt),
        .bus_idle(bus_idle)
    );

    task automatic quiet();
        cpu_sleep = 0; cpu_rel = 0; cpu_lock = 0;
        req_dtc = 0; dtc_rel = 0; dtc_lock = 0;
        req_dma = 0; dma_xfer_end = 0; dma_block_end = 0; dma_all_end = 0;
        dma_lock = 0; dma_mode = 2'd0;
    endtask

    // Let one rising edge pass, then return on the falling edge.
    task automatic tick();
        @(negedge clk);
    endtask

    // Clear all one-cycle strobes.
    task automatic drop_strobes();
        cpu_rel = 0; dtc_rel = 0; dma_xfer_end = 0; dma_block_end = 0; dma_all_end = 0;
    endtask

    task automatic chk_gnt(string tag, logic [2:0] exp);
        total++;
        if (gnt !== exp || $countones(gnt) != 1) begin
            bad++;
            $display("FAIL %s (R2 one-hot too): gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    task automatic chk_idle(string tag, logic exp);
        total++;
        if (bus_idle !== exp) begin
            bad++;
            $display("FAIL %s: bus_idle=%b expected=%b", tag, bus_idle, exp);
        end
    endtask

    // Hand the bus from the processor to the DMA at a processor boundary.
    task automatic take_dma(logic [1:0] mode);
        dma_mode = mode; req_dma = 1; cpu_rel = 1;
        tick(); drop_strobes();
        chk_gnt("R4 processor to DMA", G_DMA);
    endtask

    task automatic t_reset();
        quiet(); rst_n = 0;
        tick(); tick();
        rst_n = 1;
        chk_gnt("R1 reset grant", G_CPU);
        chk_idle("R11 awake, not idle", 1'b0);
    endtask

    task automatic t_cpu_to_dtc();
        req_dtc = 1;
        tick(); chk_gnt("R3 no boundary, hold", G_CPU);
        cpu_rel = 1; cpu_lock = 1;
        tick(); chk_gnt("R5 locked boundary ignored", G_CPU);
        cpu_lock = 0;
        tick(); drop_strobes(); chk_gnt("R4 DTC at boundary", G_DTC);
    endtask

    task automatic t_dtc_lock();
        req_dma = 1; dtc_rel = 1; dtc_lock = 1;
        tick(); chk_gnt("R7 DTC locked phase", G_DTC);
        dtc_lock = 0;
        tick(); drop_strobes(); chk_gnt("R4 DMA over DTC", G_DMA);
        req_dma = 0; dma_mode = 2'd0; dma_xfer_end = 1;
        tick(); drop_strobes(); chk_gnt("R4 back to DTC", G_DTC);
        req_dtc = 0; dtc_rel = 1;
        tick(); drop_strobes(); chk_gnt("R4 back to processor", G_CPU);
    endtask

    task automatic t_dma_single(logic [1:0] mode);
        take_dma(mode);
        req_dtc = 1; dma_xfer_end = 1;
        tick(); drop_strobes(); chk_gnt("R12 DMA keeps bus", G_DMA);
        dma_lock = 1; req_dma = 0; dma_xfer_end = 1;
        tick(); drop_strobes(); chk_gnt("R3 DMA lock holds", G_DMA);
        dma_lock = 0; dma_xfer_end = 1;
        tick(); drop_strobes(); chk_gnt("R8 per-transfer release", G_DTC);
        req_dtc = 0; dtc_rel = 1;
        tick(); drop_strobes(); chk_gnt("R4 DTC done", G_CPU);
    endtask

    task automatic t_dma_block();
        take_dma(2'd2);
        req_dma = 0; dma_xfer_end = 1;
        tick(); drop_strobes(); chk_gnt("R9 transfer end ignored", G_DMA);
        dma_block_end = 1;
        tick(); drop_strobes(); chk_gnt("R9 block end releases", G_CPU);
    endtask

    task automatic t_dma_burst();
        take_dma(2'd3);
        req_dma = 0; dma_xfer_end = 1; dma_block_end = 1;
        tick(); drop_strobes(); chk_gnt("R10 partial ends ignored", G_DMA);
        dma_all_end = 1;
        tick(); drop_strobes(); chk_gnt("R10 job end releases", G_CPU);
    endtask

    task automatic t_sleep();
        cpu_sleep = 1;
        tick(); chk_idle("R11 asleep and quiet", 1'b1);
        chk_gnt("R6 no request, processor stays", G_CPU);
        req_dma = 1; cpu_lock = 1;
        #1 chk_idle("R11 request clears idle", 1'b0);
        tick(); chk_gnt("R6 sleep handover", G_DMA);
        chk_idle("R11 DMA owns", 1'b0);
        req_dma = 0; dma_mode = 2'd0; dma_xfer_end = 1;
        tick(); drop_strobes(); chk_gnt("R4 return to sleeper", G_CPU);
        chk_idle("R11 idle again", 1'b1);
        quiet();
    endtask

    initial begin
        quiet();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_cpu_to_dtc();
        t_dtc_lock();
        t_dma_single(2'd0);
        t_dma_single(2'd1);
        t_dma_block();
        t_dma_burst();
        t_sleep();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule